// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This block keeps calendar time (seconds, minutes, hours, day of week, date, month, year and century) in packed BCD and presents it to software as a window of sixteen byte-wide registers on a simple synchronous register bus. A one-cycle tick input advances the running counters once per second. Software never touches the counters directly. It reads and writes a visible holding copy, which normally follows the counters on every cycle.

Two control bits in the flags register govern the holding copy. The freeze bit stops the copy so that a multi-byte time can be read without tearing, while the counters keep running. The write bit stops the copy so that software can load a new time. Clearing it moves the whole copy into the counters at once. Every value written in write mode is also kept as the base time. After reset, a power-up check waits a configurable number of system clocks for the oscillator-good input. If that input never appears and the oscillator is enabled, the block raises the oscillator-failed flag and restores the counters from the base time. A stop bit in the oscillator register freezes the counters.

Top module: `bcd_calendar_core`

## Requirements
- R1: Register offsets. 0x0 is flags (bit 0 freeze, bit 1 write mode, bit 2 oscillator-failed). 0x1 is century. 0x8 is the oscillator register (bit 7 = stop, active-low enable). 0x9 to 0xF are seconds, minutes, hours, day of week, date, month and year. Read data is captured on the clock edge at which the read strobe is high.
- R2: After reset the time is 2000-01-01 00:00:00 with day of week 1, and the flags and oscillator registers read 0x00.
- R3: Undefined bits and offsets read as 0 and ignore writes. The defined bits are: seconds and minutes [6:0], hours and date [5:0], day of week [2:0], month [4:0], year and century [7:0].
- R4: Each tick advances seconds, minutes and hours in 24-hour BCD with carries. On a day carry the day of week steps 1..7 and wraps from 7 to 1.
- R5: The date wraps after the month's last day (30 for months 4, 6, 9, 11; 28 or 29 for month 2; 31 otherwise). A leap year has a year divisible by 4, or year 00 with a century divisible by 4. The month wraps 12 to 1, the year 99 to 00 with a century carry, and the century 99 to 00.
- R6: While freeze is set, the visible registers hold their values and ticks are still counted. Clearing freeze reloads every visible register from the counters at once, with no seconds lost.
- R7: Time-register writes take effect only while write mode is already set. In write mode the visible registers hold. A flags write that clears write mode loads all visible time fields into the counters, and ticks counted in write mode are discarded.
- R8: Each time-register write made in write mode is also stored as the base time.
- R9: After reset release, a window of CHK_CYCLES system clocks runs. If the oscillator-good input was never high in that window and the stop bit is 0 at its end, the oscillator-failed flag is set and the counters reload the base time. The oscillator register is not changed.
- R10: The oscillator-failed flag clears only through a flags write with bit 2 = 0 made while write mode was already 1. Writing 1 to bit 2 never sets it.
- R11: While the oscillator stop bit is 1, ticks are ignored and the counters hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| osc_ok | input | 1 | Oscillator-running indication for the power-up check |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data |

## Verification
The carry chain is exercised in three ways. A per-tick walk across a century boundary separates second, minute, hour, day, month, year and century carries. A sweep loads the last day of every month, which separates the 30-, 31- and February lengths. A year set of 1900, 2000, 2023, 2024, 2100 and 2400 separates the divide-by-4 rule from the century rule. The holding layer is tested with ticks applied during freeze, during write mode and with no mode set, which distinguishes held views, discarded ticks and lost ticks. A second reset with the oscillator-good input held low shows whether time falls back to the written base time or to the reset time, and which flags-write sequence may clear the failure flag.

// File: rtl/calclk_pkg.sv
package calclk_pkg;

   typedef struct packed {
      logic [7:0] cen;
      logic [7:0] yr;
      logic [7:0] mon;
      logic [7:0] date;
      logic [7:0] dow;
      logic [7:0] hrs;
      logic [7:0] mins;
      logic [7:0] sec;
   } caltime_t;

   localparam logic [3:0] OFS_FLAGS = 4'h0;
   localparam logic [3:0] OFS_CEN   = 4'h1;
   localparam logic [3:0] OFS_OSC   = 4'h8;
   localparam logic [3:0] OFS_SEC   = 4'h9;
   localparam logic [3:0] OFS_MIN   = 4'hA;
   localparam logic [3:0] OFS_HRS   = 4'hB;
   localparam logic [3:0] OFS_DOW   = 4'hC;
   localparam logic [3:0] OFS_DATE  = 4'hD;
   localparam logic [3:0] OFS_MON   = 4'hE;
   localparam logic [3:0] OFS_YR    = 4'hF;

   localparam caltime_t TIME_RESET = '{cen: 8'h20, yr: 8'h00, mon: 8'h01, date: 8'h01,
                                       dow: 8'h01, hrs: 8'h00, mins: 8'h00, sec: 8'h00};

   // defined bits per time offset; zero marks a non-time offset
   function automatic logic [7:0] field_mask(input logic [3:0] ofs);
      case (ofs)
         OFS_SEC, OFS_MIN:  return 8'h7F;
         OFS_HRS, OFS_DATE: return 8'h3F;
         OFS_DOW:           return 8'h07;
         OFS_MON:           return 8'h1F;
         OFS_YR, OFS_CEN:   return 8'hFF;
         default:           return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] get_field(input caltime_t t, input logic [3:0] ofs);
      case (ofs)
         OFS_SEC:  return t.sec;
         OFS_MIN:  return t.mins;
         OFS_HRS:  return t.hrs;
         OFS_DOW:  return t.dow;
         OFS_DATE: return t.date;
         OFS_MON:  return t.mon;
         OFS_YR:   return t.yr;
         OFS_CEN:  return t.cen;
         default:  return 8'h00;
      endcase
   endfunction

   function automatic caltime_t put_field(input caltime_t t, input logic [3:0] ofs,
                                          input logic [7:0] d);
      caltime_t n;
      logic [7:0] v;
      n = t;
      v = d & field_mask(ofs);
      case (ofs)
         OFS_SEC:  n.sec  = v;
         OFS_MIN:  n.mins = v;
         OFS_HRS:  n.hrs  = v;
         OFS_DOW:  n.dow  = v;
         OFS_DATE: n.date = v;
         OFS_MON:  n.mon  = v;
         OFS_YR:   n.yr   = v;
         OFS_CEN:  n.cen  = v;
         default:  n = t;
      endcase
      return n;
   endfunction

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // BCD value divisible by four: (2*tens + ones) mod 4 == 0
   function automatic logic bcd_div4(input logic [7:0] v);
      logic [1:0] s;
      s = {v[4], 1'b0} + v[1:0];
      return s == 2'b00;
   endfunction

   function automatic logic [7:0] last_day(input logic [7:0] mon, input logic leap);
      case (mon)
         8'h02:                      return leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   function automatic caltime_t next_time(input caltime_t t);
      caltime_t n;
      logic     leap;
      n    = t;
      leap = (t.yr == 8'h00) ? bcd_div4(t.cen) : bcd_div4(t.yr);
      if (t.sec != 8'h59) n.sec = bcd_inc(t.sec);
      else begin
         n.sec = 8'h00;
         if (t.mins != 8'h59) n.mins = bcd_inc(t.mins);
         else begin
            n.mins = 8'h00;
            if (t.hrs != 8'h23) n.hrs = bcd_inc(t.hrs);
            else begin
               n.hrs = 8'h00;
               n.dow = (t.dow >= 8'h07 || t.dow == 8'h00) ? 8'h01 : t.dow + 8'd1;
               if (t.date != last_day(t.mon, leap)) n.date = bcd_inc(t.date);
               else begin
                  n.date = 8'h01;
                  if (t.mon != 8'h12) n.mon = bcd_inc(t.mon);
                  else begin
                     n.mon = 8'h01;
                     if (t.yr != 8'h99) n.yr = bcd_inc(t.yr);
                     else begin
                        n.yr  = 8'h00;
                        n.cen = (t.cen == 8'h99) ? 8'h00 : bcd_inc(t.cen);
                     end
                  end
               end
            end
         end
      end
      return n;
   endfunction

endpackage

// File: rtl/calclk_counter.sv
module calclk_counter
   import calclk_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     adv,
   input  logic     load,
   input  caltime_t load_val,
   output caltime_t now
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    now <= TIME_RESET;
      else if (load) now <= load_val;
      else if (adv)  now <= next_time(now);
   end

endmodule

// File: rtl/calclk_osc_check.sv
module calclk_osc_check #(
   parameter int unsigned CHK_CYCLES = 250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_ok,
   input  logic osc_stop,
   output logic fail
);

   localparam int unsigned CW = (CHK_CYCLES > 2) ? $clog2(CHK_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(CHK_CYCLES - 1);

   logic [CW-1:0] cnt;
   logic          active;
   logic          seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         active <= 1'b1;
         seen   <= 1'b0;
         fail   <= 1'b0;
      end else begin
         fail <= 1'b0;
         if (active) begin
            if (osc_ok) seen <= 1'b1;
            if (cnt == LAST) begin
               active <= 1'b0;
               fail   <= !seen && !osc_ok && !osc_stop;
            end else begin
               cnt <= cnt + CW'(1);
            end
         end
      end
   end

endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
   import calclk_pkg::*;
#(
   parameter int unsigned CHK_CYCLES = 250000,
   parameter bit          RD_REG     = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_1hz,
   input  logic       osc_ok,
   input  logic [3:0] reg_addr,
   input  logic [7:0] reg_wdata,
   input  logic       reg_wr,
   input  logic       reg_rd,
   output logic [7:0] reg_rdata
);

   if (CHK_CYCLES < 2) begin : g_bad_window
      $error("CHK_CYCLES must be at least 2");
   end

   logic     frz_q, wen_q, oscf_q, osc_stop_q;
   caltime_t vis, base, run, ld_val;
   logic     flag_wr, time_wr, osc_wr, w_release, ld, fail;
   logic [7:0] rd_val;

   assign flag_wr   = reg_wr && (reg_addr == OFS_FLAGS);
   assign osc_wr    = reg_wr && (reg_addr == OFS_OSC);
   assign time_wr   = reg_wr && wen_q && (field_mask(reg_addr) != 8'h00);
   assign w_release = flag_wr && wen_q && !reg_wdata[1];
   assign ld        = fail || w_release;
   assign ld_val    = fail ? base : vis;

   calclk_counter i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (tick_1hz && !osc_stop_q),
      .load     (ld),
      .load_val (ld_val),
      .now      (run)
   );

   calclk_osc_check #(.CHK_CYCLES(CHK_CYCLES)) i_oschk (
      .clk      (clk),
      .rst_n    (rst_n),
      .osc_ok   (osc_ok),
      .osc_stop (osc_stop_q),
      .fail     (fail)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vis        <= TIME_RESET;
         base       <= TIME_RESET;
         frz_q      <= 1'b0;
         wen_q      <= 1'b0;
         oscf_q     <= 1'b0;
         osc_stop_q <= 1'b0;
      end else begin
         if (time_wr) begin
            vis  <= put_field(vis, reg_addr, reg_wdata);
            base <= put_field(base, reg_addr, reg_wdata);
         end else if (!frz_q && !wen_q) begin
            vis <= run;
         end
         if (flag_wr) begin
            frz_q <= reg_wdata[0];
            wen_q <= reg_wdata[1];
            if (wen_q && !reg_wdata[2]) oscf_q <= 1'b0;
         end
         if (fail) oscf_q <= 1'b1;
         if (osc_wr) osc_stop_q <= reg_wdata[7];
      end
   end

   always_comb begin
      case (reg_addr)
         OFS_FLAGS: rd_val = {5'b0, oscf_q, wen_q, frz_q};
         OFS_OSC:   rd_val = {osc_stop_q, 7'b0};
         default:   rd_val = get_field(vis, reg_addr);
      endcase
   end

   if (RD_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      reg_rdata <= 8'h00;
         else if (reg_rd) reg_rdata <= rd_val;
      end
   end else begin : g_rd_comb
      assign reg_rdata = rd_val;
   end

endmodule

// File: rtl/calclk_checker.sv
module calclk_checker
   import calclk_pkg::*;
(
   input logic     clk,
   input logic     rst_n,
   input logic     frz_q,
   input logic     wen_q,
   input logic     oscf_q,
   input logic     osc_stop_q,
   input logic     flag_wr,
   input logic     wd_oscf,
   input logic     ld,
   input logic     fail,
   input caltime_t vis,
   input caltime_t run,
   input caltime_t base
);

   // R6: frozen view does not move
   a_r6_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
      $past(frz_q) && !$past(wen_q) |-> $stable(vis));

   // R6: without freeze or write mode the view tracks the counters one cycle later
   a_r6_view_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(frz_q) && !$past(wen_q) |-> vis == $past(run));

   // R7: leaving write mode copies the view into the counters
   a_r7_release_loads: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ld) && !$past(fail) |-> run == $past(vis));

   // R9 and R8: power-up failure restores base time and raises the flag
   a_r9_fail_restores_base: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fail) |-> run == $past(base) && oscf_q);

   // R10: flag clears only by a flags write made in write mode
   a_r10_oscf_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oscf_q) |-> $past(flag_wr) && $past(wen_q) && !$past(wd_oscf));

   // R11: stopped oscillator keeps the counters still
   a_r11_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
      $past(osc_stop_q) && !$past(ld) |-> $stable(run));

endmodule

bind bcd_calendar_core calclk_checker i_calclk_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .frz_q      (frz_q),
   .wen_q      (wen_q),
   .oscf_q     (oscf_q),
   .osc_stop_q (osc_stop_q),
   .flag_wr    (flag_wr),
   .wd_oscf    (reg_wdata[2]),
   .ld         (ld),
   .fail       (fail),
   .vis        (vis),
   .run        (run),
   .base       (base)
);

// File: tb/test_bcd_calendar_core.sv
module test_bcd_calendar_core;

   localparam int CLK_PERIOD = 10;
   localparam int WIN        = 400;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       osc_ok = 1'b1;
   logic [3:0] addr = 4'h0;
   logic [7:0] wdata = 8'h00;
   logic       wr = 1'b0;
   logic       rd = 1'b0;
   logic [7:0] rdata;

   int checks = 0;
   int fails  = 0;
   int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_year;

   always #(CLK_PERIOD/2) clk = ~clk;

   bcd_calendar_core #(.CHK_CYCLES(WIN), .RD_REG(1'b1)) i_bcd_calendar_core (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .osc_ok(osc_ok),
      .reg_addr(addr), .reg_wdata(wdata), .reg_wr(wr), .reg_rd(rd), .reg_rdata(rdata)
   );

   function automatic logic [7:0] bcd(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int dim(input int mon, input int yr);
      bit leap;
      leap = ((yr % 4 == 0) && (yr % 100 != 0)) || (yr % 400 == 0);
      if (mon == 2) return leap ? 29 : 28;
      if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
      return 31;
   endfunction

   task automatic model_tick();
      m_sec++;
      if (m_sec == 60) begin m_sec = 0; m_min++; end
      if (m_min == 60) begin m_min = 0; m_hr++; end
      if (m_hr == 24) begin
         m_hr = 0;
         m_dow = (m_dow == 7) ? 1 : m_dow + 1;
         m_date++;
         if (m_date > dim(m_mon, m_year)) begin
            m_date = 1;
            m_mon++;
            if (m_mon == 13) begin m_mon = 1; m_year = (m_year + 1) % 10000; end
         end
      end
   endtask

   task automatic model_reset();
      m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_date = 1; m_mon = 1; m_year = 2000;
   endtask

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd = 1'b1;
      @(negedge clk);
      d = rdata; rd = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
      logic [7:0] d;
      bus_rd(a, d);
      chk(tag, d, exp);
   endtask

   task automatic ticks(input int n, input bit model);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
         if (model) model_tick();
      end
   endtask

   task automatic check_time(input string tag);
      rd_chk(tag, 4'h9, bcd(m_sec));
      rd_chk(tag, 4'hA, bcd(m_min));
      rd_chk(tag, 4'hB, bcd(m_hr));
      rd_chk(tag, 4'hC, bcd(m_dow));
      rd_chk(tag, 4'hD, bcd(m_date));
      rd_chk(tag, 4'hE, bcd(m_mon));
      rd_chk(tag, 4'hF, bcd(m_year % 100));
      rd_chk(tag, 4'h1, bcd(m_year / 100));
   endtask

   task automatic set_time(input int y, input int mo, input int d, input int dw,
                           input int h, input int mi, input int s);
      bus_wr(4'h0, 8'h02);
      bus_wr(4'h1, bcd(y / 100));
      bus_wr(4'hF, bcd(y % 100));
      bus_wr(4'hE, bcd(mo));
      bus_wr(4'hD, bcd(d));
      bus_wr(4'hC, bcd(dw));
      bus_wr(4'hB, bcd(h));
      bus_wr(4'hA, bcd(mi));
      bus_wr(4'h9, bcd(s));
      bus_wr(4'h0, 8'h00);
      m_year = y; m_mon = mo; m_date = d; m_dow = dw; m_hr = h; m_min = mi; m_sec = s;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int yrs[6];
      int sv_y, sv_mo, sv_d, sv_dw, sv_h, sv_mi, sv_s;
      do_reset();

      // R2 and R1: reset contents
      check_time("R2");
      rd_chk("R2 flags", 4'h0, 8'h00);
      rd_chk("R2 osc", 4'h8, 8'h00);

      // R9: oscillator good during window, no failure
      repeat (WIN + 20) @(negedge clk);
      rd_chk("R9 no fail", 4'h0, 8'h00);

      // R3: undefined offset and flag bits
      bus_wr(4'h3, 8'hFF);
      rd_chk("R3 offset", 4'h3, 8'h00);
      bus_wr(4'h0, 8'hFC);
      rd_chk("R3 flags", 4'h0, 8'h00);

      // R4: seconds/minutes/hours carries, per tick
      set_time(2023, 6, 14, 3, 10, 59, 58);
      for (int i = 0; i < 3; i++) begin
         ticks(1, 1'b1);
         check_time("R4");
      end
      set_time(2023, 6, 14, 7, 23, 59, 59);
      ticks(1, 1'b1);
      check_time("R4 dow wrap");

      // R5: last day of every month
      for (int mo = 1; mo <= 12; mo++) begin
         set_time(2023, mo, dim(mo, 2023), 2, 23, 59, 59);
         ticks(1, 1'b1);
         check_time("R5 month");
      end

      // R5: leap rules on the end of February
      yrs = '{1900, 2000, 2023, 2024, 2100, 2400};
      foreach (yrs[k]) begin
         set_time(yrs[k], 2, 28, 4, 23, 59, 59);
         ticks(1, 1'b1);
         check_time("R5 leap");
      end

      // R5: century rollover walked per tick
      set_time(2099, 12, 31, 5, 23, 59, 57);
      for (int i = 0; i < 4; i++) begin
         ticks(1, 1'b1);
         check_time("R5 century");
      end
      set_time(9999, 12, 31, 6, 23, 59, 59);
      ticks(1, 1'b1);
      check_time("R5 top wrap");

      // R6: freeze holds the view, ticks still counted
      bus_wr(4'h0, 8'h01);
      rd_chk("R6 flags", 4'h0, 8'h01);
      sv_s = m_sec;
      ticks(3, 1'b1);
      rd_chk("R6 frozen", 4'h9, bcd(sv_s));
      bus_wr(4'h0, 8'h00);
      check_time("R6 no loss");

      // R7: writes without write mode are ignored
      bus_wr(4'h9, 8'h11);
      rd_chk("R7 ignored", 4'h9, bcd(m_sec));

      // R7 and R3: write mode, masked hours, discarded ticks
      bus_wr(4'h0, 8'h02);
      bus_wr(4'h9, 8'h30);
      bus_wr(4'hB, 8'hC0 | bcd(m_hr));
      ticks(2, 1'b0);
      rd_chk("R7 held", 4'h9, 8'h30);
      rd_chk("R3 hrs mask", 4'hB, bcd(m_hr));
      bus_wr(4'h0, 8'h00);
      m_sec = 30;
      check_time("R7 loaded");
      ticks(1, 1'b1);
      rd_chk("R7 resumes", 4'h9, bcd(m_sec));

      // R11: stop bit freezes counting
      bus_wr(4'h8, 8'h80);
      rd_chk("R11 osc reg", 4'h8, 8'h80);
      ticks(3, 1'b0);
      check_time("R11 stopped");
      bus_wr(4'h8, 8'h7F);
      rd_chk("R3 osc bits", 4'h8, 8'h00);
      ticks(1, 1'b1);
      rd_chk("R11 restarted", 4'h9, bcd(m_sec));

      // R8 and R9: failed oscillator at power-up restores base time
      osc_ok = 1'b0;
      do_reset();
      set_time(2042, 7, 4, 5, 12, 34, 56);
      sv_y = m_year; sv_mo = m_mon; sv_d = m_date; sv_dw = m_dow;
      sv_h = m_hr; sv_mi = m_min; sv_s = m_sec;
      ticks(5, 1'b1);
      check_time("R9 before window");
      repeat (WIN + 20) @(negedge clk);
      rd_chk("R9 oscf set", 4'h0, 8'h04);
      m_year = sv_y; m_mon = sv_mo; m_date = sv_d; m_dow = sv_dw;
      m_hr = sv_h; m_min = sv_mi; m_sec = sv_s;
      check_time("R8 base restored");
      rd_chk("R9 osc reg kept", 4'h8, 8'h00);

      // R10: clearing the failure flag
      bus_wr(4'h0, 8'h00);
      rd_chk("R10 no W", 4'h0, 8'h04);
      bus_wr(4'h0, 8'h02);
      rd_chk("R10 W just set", 4'h0, 8'h06);
      bus_wr(4'h0, 8'h02);
      rd_chk("R10 cleared", 4'h0, 8'h02);
      bus_wr(4'h0, 8'h04);
      rd_chk("R10 no set", 4'h0, 8'h00);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule